// File: doc/BRIEF.md
# Planar Video Pixel Serializer

This block sits between the video memory fetch path and the palette stage of a display pipeline. Each fetch delivers one 32-bit word made of one byte from each of four memory planes. The block holds that word and hands out one color index per pixel-clock enable. A format input chooses how the word is split into pixels.

There are three formats. In 16-color planar format one bit position is gathered across all four planes to build a 4-bit index, which gives eight pixels per word. In linear 256-color format only the plane 0 byte is used, as one 8-bit pixel per word. In unchained 256-color format the four plane bytes are four consecutive 8-bit pixels.

A request output tells the fetch logic when the held word is nearly used up. A blanking input forces a zero index and freezes the pixel position. The format is sampled only when a word is loaded, so a new format never applies to a word that is part-way through being sent out.

Top module: `planar_pixel_serializer`

## Requirements
- R1: While `rst` is high at a clock edge, `pix_index` becomes 0 and `fetch_req` becomes 1, and the buffer is empty.
- R2: In format 0 (16-color planar), a word gives 8 pixels. Pixel p (p = 0 first) has bit n equal to bit (7-p) of plane n's byte (plane n is `fetch_data[8n+7:8n]`). Bits 7:4 of the index are zero.
- R3: In format 0, plane bytes 0xF0, 0x3C, 0x66 and 0xAA for planes 0 to 3 produce the pixel sequence 9, 5, 15, 3, 10, 6, 12, 0.
- R4: In format 1 (linear), a word gives one pixel equal to the plane 0 byte, and the other three bytes have no effect.
- R5: In format 2 (unchained), a word gives four pixels: plane 0's byte, then plane 1, plane 2 and plane 3.
- R6: `fetch_req` is a registered level. It is 1 in the cycle after any edge that leaves at most one unsent pixel in the buffer, and 0 otherwise.
- R7: A word on `fetch_data` with `fetch_valid` high is loaded only when the buffer is empty, or when its last pixel is being sent at that same edge. Otherwise the word is ignored and output continues from the held word.
- R8: At an edge where `blank` is high, `pix_index` becomes 0 and no pixel is consumed, so output resumes at the same pixel afterwards.
- R9: At an edge where `pix_en` and `blank` are both low, `pix_index` holds and no pixel is consumed.
- R10: At an edge where `pix_en` is high, `blank` is low and the buffer is empty, `pix_index` becomes 0.
- R11: The format is captured when a word loads. Changes on `mode` do not alter how a word that is already held is split.
- R12: Format 3 behaves exactly like format 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Pixel format: 0 planar 16-color, 1 linear, 2 unchained, 3 same as 1 |
| fetch_valid | input | 1 | A fetched word is present on `fetch_data` |
| fetch_data | input | 32 | Four plane bytes, plane n in bits 8n+7:8n |
| fetch_req | output | 1 | Buffer holds at most one unsent pixel |
| pix_en | input | 1 | Pixel-clock enable |
| blank | input | 1 | Force a zero index and stall pixel output |
| pix_index | output | 8 | Registered color index |

## Verification
The bench goes after the edges where a load meets the last pixel. If the design accepted a word one pixel early, pixels would be lost. If it refused the word when the last pixel left, a gap of zeros would appear.

It also keeps the format changing while words are part-way out. A design that used the live format would scramble the remaining pixels of the held word.

Blank and enable are toggled at random. A design that advanced during blank would skip pixels, and one that did not clear the index would leak color.

The fixed plane pattern catches a reversed bit order, which would play the eight-pixel sequence backwards, and a swapped plane order, which would mix up the index bits.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    FMT_PLANAR16  = 2'd0,
    FMT_LINEAR    = 2'd1,
    FMT_UNCHAINED = 2'd2,
    FMT_SPARE     = 2'd3
  } fmt_e;
endpackage

// File: rtl/pps_pixel_pick.sv
module pps_pixel_pick
  import pps_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8,
  parameter int POS_W  = 3
) (
  input  logic [PLANES*BYTE_W-1:0] word,
  input  fmt_e                     fmt,
  input  logic [POS_W-1:0]         pos,
  output logic [BYTE_W-1:0]        pixel
);
  localparam int PSEL_W = (PLANES > 1) ? $clog2(PLANES) : 1;

  logic [BYTE_W-1:0] pbyte [PLANES];
  logic [PLANES-1:0] planar;
  logic [POS_W-1:0]  bsel;
  logic [PSEL_W-1:0] psel;

  assign bsel = POS_W'(BYTE_W - 1) - pos;
  assign psel = pos[PSEL_W-1:0];

  for (genvar n = 0; n < PLANES; n++) begin : g_plane
    assign pbyte[n]  = word[n*BYTE_W +: BYTE_W];
    assign planar[n] = pbyte[n][bsel];
  end

  always_comb begin
    case (fmt)
      FMT_PLANAR16:  pixel = BYTE_W'(planar);
      FMT_UNCHAINED: pixel = pbyte[psel];
      default:       pixel = pbyte[0];
    endcase
  end
endmodule

// File: rtl/pps_word_buffer.sv
module pps_word_buffer
  import pps_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8,
  parameter int POS_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fetch_valid,
  input  logic [PLANES*BYTE_W-1:0] fetch_data,
  input  fmt_e                     fmt_in,
  input  logic                     adv,
  output logic [PLANES*BYTE_W-1:0] word_q,
  output fmt_e                     fmt_q,
  output logic [POS_W-1:0]         pos_q,
  output logic                     has,
  output logic                     req_next
);
  localparam int MAXPIX = (BYTE_W > PLANES) ? BYTE_W : PLANES;

  logic [CNT_W-1:0] left_q, left_d, load_cnt;
  logic             take, load;

  always_comb begin
    case (fmt_in)
      FMT_PLANAR16:  load_cnt = CNT_W'(BYTE_W);
      FMT_UNCHAINED: load_cnt = CNT_W'(PLANES);
      default:       load_cnt = CNT_W'(1);
    endcase
  end

  assign has  = (left_q != '0);
  assign take = adv && has;
  assign load = fetch_valid && (!has || (take && left_q == CNT_W'(1)));

  always_comb begin
    if (load)      left_d = load_cnt;
    else if (take) left_d = left_q - CNT_W'(1);
    else           left_d = left_q;
  end

  assign req_next = (left_d <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      pos_q  <= '0;
      word_q <= '0;
      fmt_q  <= FMT_PLANAR16;
    end else begin
      left_q <= left_d;
      if (load) begin
        pos_q  <= '0;
        word_q <= fetch_data;
        fmt_q  <= fmt_in;
      end else if (take) begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  // R7: a word offered while more than one pixel remains is not stored
  a_r7_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (left_q > CNT_W'(1) && fetch_valid) |=> $stable(word_q));
  // R11: format stays put while the held word is not yet finished
  a_r11_fmt_held: assert property (@(posedge clk) disable iff (rst)
    (left_q > CNT_W'(1)) |=> $stable(fmt_q));
  // R6: pixel count never exceeds one full word
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    left_q <= CNT_W'(MAXPIX));
endmodule

// File: rtl/planar_pixel_serializer.sv
module planar_pixel_serializer
  import pps_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode,
  input  logic                     fetch_valid,
  input  logic [PLANES*BYTE_W-1:0] fetch_data,
  output logic                     fetch_req,
  input  logic                     pix_en,
  input  logic                     blank,
  output logic [BYTE_W-1:0]        pix_index
);
  localparam int MAXPIX = (BYTE_W > PLANES) ? BYTE_W : PLANES;
  localparam int POS_W  = (MAXPIX > 1) ? $clog2(MAXPIX) : 1;
  localparam int CNT_W  = $clog2(MAXPIX + 1);

  logic [PLANES*BYTE_W-1:0] word_q;
  fmt_e                     fmt_q;
  logic [POS_W-1:0]         pos_q;
  logic                     has, req_next, adv;
  logic [BYTE_W-1:0]        pixel;

  assign adv = pix_en && !blank;

  pps_word_buffer #(
    .PLANES(PLANES), .BYTE_W(BYTE_W), .POS_W(POS_W), .CNT_W(CNT_W)
  ) u_buf (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .fmt_in(fmt_e'(mode)), .adv(adv),
    .word_q(word_q), .fmt_q(fmt_q), .pos_q(pos_q),
    .has(has), .req_next(req_next)
  );

  pps_pixel_pick #(
    .PLANES(PLANES), .BYTE_W(BYTE_W), .POS_W(POS_W)
  ) u_pick (
    .word(word_q), .fmt(fmt_q), .pos(pos_q), .pixel(pixel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_index <= '0;
      fetch_req <= 1'b1;
    end else begin
      fetch_req <= req_next;
      if (blank)       pix_index <= '0;
      else if (pix_en) pix_index <= has ? pixel : '0;
    end
  end

  // R8: blanking clears the index
  a_r8_blank_zero: assert property (@(posedge clk) disable iff (rst)
    blank |=> (pix_index == '0));
  // R9: no enable, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!pix_en && !blank) |=> $stable(pix_index));
  // R10: empty buffer yields index zero
  a_r10_underrun: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !blank && !has) |=> (pix_index == '0));
  // R6: an empty buffer is always being requested
  a_r6_req_when_empty: assert property (@(posedge clk) disable iff (rst)
    !has |-> fetch_req);
  // R2: planar pixels use only the low plane-count bits
  a_r2_planar_high_zero: assert property (@(posedge clk) disable iff (rst)
    (adv && has && fmt_q == FMT_PLANAR16) |=> (pix_index[BYTE_W-1:PLANES] == '0));
endmodule

// File: tb/planar_pixel_serializer_bench.sv
`timescale 1ns/1ps
module planar_pixel_serializer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_data = '0;
  logic        fetch_req;
  logic        pix_en = 1'b0;
  logic        blank = 1'b0;
  logic [7:0]  pix_index;

  int    checks = 0;
  int    fails  = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  int q[$];
  int exp_idx = 0;
  bit exp_req = 1'b1;

  always #10 clk = ~clk;

  planar_pixel_serializer u_planar_pixel_serializer (
    .clk(clk), .rst(rst), .mode(mode),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_req(fetch_req),
    .pix_en(pix_en), .blank(blank), .pix_index(pix_index)
  );

  // Reference model: queue of pixels still to be sent
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      exp_idx = 0;
      exp_req = 1'b1;
    end else begin
      bit adv, last, accept;
      adv    = pix_en && !blank;
      last   = adv && (q.size() == 1);
      accept = fetch_valid && (q.size() == 0 || last);
      if (blank) exp_idx = 0;
      else if (pix_en) exp_idx = (q.size() > 0) ? q.pop_front() : 0;
      if (accept) begin
        if (mode == 2'd0) begin
          for (int p = 0; p < 8; p++) begin
            int v;
            v = 0;
            for (int n = 0; n < 4; n++) v += int'(fetch_data[n*8 + 7 - p]) << n;
            q.push_back(v);
          end
        end else if (mode == 2'd2) begin
          for (int p = 0; p < 4; p++) q.push_back(int'(fetch_data[p*8 +: 8]));
        end else begin
          q.push_back(int'(fetch_data[7:0]));
        end
      end
      exp_req = (q.size() <= 1);
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      checks++;
      if (int'(pix_index) != exp_idx) begin
        fails++;
        $display("FAIL %s pix_index actual %0d expected %0d at %0t", cur_req, pix_index, exp_idx, $time);
      end
      checks++;
      if (fetch_req != exp_req) begin
        fails++;
        $display("FAIL %s fetch_req actual %0d expected %0d at %0t", cur_req, fetch_req, exp_req, $time);
      end
    end
  end

  // vmode: 0 never, 1 follow fetch_req, 2 always; emode/bmode: 0 off, 1 random, 2 on
  task automatic run(input string tag, input int n, input int md, input int vmode,
                     input int emode, input int bmode);
    cur_req = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mode        = (md < 0) ? 2'($urandom_range(0, 2)) : 2'(md);
      fetch_valid = (vmode == 2) || (vmode == 1 && fetch_req);
      fetch_data  = $urandom;
      pix_en      = (emode == 2) || (emode == 1 && $urandom_range(0, 1) == 1);
      blank       = (bmode == 2) || (bmode == 1 && $urandom_range(0, 3) == 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seq [8] = '{9, 5, 15, 3, 10, 6, 12, 0};
    // R1: reset state
    chk_on = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk) rst = 1'b0;

    // R3 and R2: fixed plane pattern after draining
    run("R10", 10, 0, 0, 2, 0);
    @(negedge clk);
    cur_req = "R3"; mode = 2'd0; fetch_valid = 1'b1; fetch_data = 32'hAA663CF0; pix_en = 1'b0;
    @(negedge clk);
    fetch_valid = 1'b0; pix_en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      checks++;
      if (int'(pix_index) != seq[k]) begin
        fails++;
        $display("FAIL R3 pixel %0d actual %0d expected %0d", k, pix_index, seq[k]);
      end
    end

    run("R2", 60, 0, 1, 2, 0);
    run("R4", 60, 1, 1, 2, 0);
    run("R5", 60, 2, 1, 2, 0);
    run("R10", 12, 2, 0, 2, 0);
    run("R9", 80, 2, 1, 1, 0);
    run("R8", 80, 0, 1, 2, 1);
    run("R7", 60, 0, 2, 2, 0);
    run("R7", 60, 2, 2, 1, 1);
    run("R11", 120, -1, 1, 1, 0);
    run("R12", 40, 3, 1, 2, 0);
    run("R6", 300, -1, 1, 1, 1);
    run("R6", 200, -1, 2, 1, 1);

    // R1: reset again mid-stream
    @(negedge clk) begin cur_req = "R1"; rst = 1'b1; end
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run("R1", 4, 0, 0, 0, 0);

    chk_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule